// File: doc/BRIEF.md
# Deserialized Lane Pattern Word Aligner

This block sits behind four 1:8 deserializers, one per serial data lane. It takes each lane's stream of 8-bit words and finds the bit offset and the byte phase at which a known 16-bit training pattern (eight ones, then eight zeros) begins. It then delivers 16-bit samples cut on that boundary. Each lane searches, qualifies and locks on its own. The lanes share only the mode input and the re-arm input.

The host first drives the link with the training pattern and holds `train_i` high until every lane reports lock. It then lowers `train_i` and switches the sender to real data, and the aligned samples appear. If the sender is reconfigured while `train_i` is high, the stream can move by a few bits. A locked lane notices the repeated mismatches, drops lock and searches again without any reset. Pulsing `realign_i` sends every lane back to search at once.

Top module: `lane_word_aligner`

## Requirements
- R1: While `rst_ni` is low, `lock_o`, `sample_vld_o` and `offset_o` are all zero.
- R2: Bits are numbered in arrival order from the first accepted word after reset or re-arm, and the first bit of each word is its MSB. In training mode a lane fed the repeating pattern 16'hFF00 locks for any boundary 0 to 15. It reports in `offset_o` the start position of the pattern modulo 16. Bit 3 of the lane field is the byte phase and bits 2:0 are the bit shift.
- R3: A lane locks only in training mode. It locks after 8 consecutive evaluated samples match the pattern at the same offset. A sample is evaluated once the word following its last bit has been accepted. So with the boundary at 0, 16 accepted words do not lock the lane, and a 17th does.
- R4: While a lane stays locked, its `offset_o` field does not change.
- R5: In training mode, a locked lane that sees 4 consecutive mismatching samples at its offset drops lock. It then searches again and relocks at the new boundary, which is the old one plus the inserted bit count, modulo 16.
- R6: In data mode, samples that differ from the pattern never drop lock.
- R7: In data mode a locked lane delivers each 16-bit sample that starts on its boundary, in order, on `sample_o`. Each sample comes with a strobe on `sample_vld_o` that is high for a single cycle. The strobe appears two clock edges after the word that completes the evaluation was accepted.
- R8: A word presented while the lane's `word_valid_i` bit is low has no effect on lock, offset or samples.
- R9: A clock edge with `realign_i` high clears the lock of every lane by the next cycle. It also restarts bit numbering.
- R10: A slip on one lane leaves the lock and the offset of the other lanes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| train_i | input | 1 | 1: training mode (search and loss detection); 0: data mode (sample output) |
| realign_i | input | 1 | Sends all lanes back to search |
| word_valid_i | input | NUM_LANES | Per-lane word valid |
| word_i | input | NUM_LANES*WORD_W | Lane l word at bits l*WORD_W +: WORD_W |
| sample_o | output | NUM_LANES*2*WORD_W | Aligned sample per lane |
| sample_vld_o | output | NUM_LANES | One-cycle sample strobe per lane |
| lock_o | output | NUM_LANES | Per-lane lock flag |
| offset_o | output | NUM_LANES*(log2(WORD_W)+1) | Per-lane boundary: {byte phase, bit shift} |

## Verification
Some rules hold on every cycle, and the bound checker watches them. Strobes come only from a locked lane, only in data mode and only two edges after an accepted word, and never on two cycles in a row. A lock rises only in training mode, the offset stays fixed while a lane is locked, and re-arm clears lock. Other behaviour needs the bench's scenarios. These are the exact boundary found for each of the sixteen offsets, the exact word count that produces lock, and relock after an inserted slip on one lane while the others stay untouched. The bench also shows that training samples still in flight at the mode switch are delivered and that data samples arrive bit-exact.

// File: rtl/lwa_pkg.sv
package lwa_pkg;
  typedef enum logic [1:0] {
    ST_SEARCH = 2'd0,
    ST_QUAL   = 2'd1,
    ST_LOCK   = 2'd2
  } lane_st_e;
endpackage

// File: rtl/lwa_shift_window.sv
module lwa_shift_window #(
  parameter int WORD_W    = 8,
  parameter int NUM_WORDS = 3,
  localparam int WIN_W    = WORD_W * NUM_WORDS,
  localparam int FILL_W   = $clog2(NUM_WORDS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              vld_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [WIN_W-1:0]  win_o,
  output logic              full_o,
  output logic              par_o,
  output logic              new_o
);
  logic [WIN_W-1:0]  win_q;
  logic [FILL_W-1:0] fill_q;
  logic              par_q;
  logic              new_q;

  // newest word in the low bits; par_q is the index parity of that word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      fill_q <= '0;
      par_q  <= 1'b1;
      new_q  <= 1'b0;
    end else if (clr_i) begin
      win_q  <= '0;
      fill_q <= '0;
      par_q  <= 1'b1;
      new_q  <= 1'b0;
    end else begin
      new_q <= vld_i;
      if (vld_i) begin
        win_q <= {win_q[WIN_W-WORD_W-1:0], word_i};
        par_q <= ~par_q;
        if (fill_q != FILL_W'(NUM_WORDS)) fill_q <= fill_q + FILL_W'(1);
      end
    end
  end

  assign win_o  = win_q;
  assign full_o = (fill_q == FILL_W'(NUM_WORDS));
  assign par_o  = par_q;
  assign new_o  = new_q;
endmodule

// File: rtl/lwa_pattern_match.sv
module lwa_pattern_match #(
  parameter int WORD_W = 8,
  parameter int SAMP_W = 16,
  parameter int WIN_W  = 24,
  parameter int SH_W   = 3,
  parameter logic [SAMP_W-1:0] PATTERN = 16'hFF00
) (
  input  logic [WIN_W-1:0]         win_i,
  output logic [WORD_W*SAMP_W-1:0] cand_o,
  output logic [WORD_W-1:0]        hit_o,
  output logic [SH_W-1:0]          first_o,
  output logic                     any_o
);
  for (genvar s = 0; s < WORD_W; s++) begin : g_shift
    assign cand_o[s*SAMP_W +: SAMP_W] = win_i[WIN_W-1-s -: SAMP_W];
    assign hit_o[s] = (win_i[WIN_W-1-s -: SAMP_W] == PATTERN);
  end

  // lowest shift wins
  always_comb begin
    first_o = '0;
    for (int s = WORD_W - 1; s >= 0; s--) begin
      if (hit_o[s]) first_o = SH_W'(s);
    end
  end

  assign any_o = |hit_o;
endmodule

// File: rtl/lwa_lane_fsm.sv
module lwa_lane_fsm
  import lwa_pkg::*;
#(
  parameter int WORD_W   = 8,
  parameter int SAMP_W   = 16,
  parameter int SH_W     = 3,
  parameter int LOCK_RUN = 8,
  parameter int LOSS_RUN = 4,
  localparam int RUN_W   = $clog2(LOCK_RUN + 1),
  localparam int MISS_W  = $clog2(LOSS_RUN + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     realign_i,
  input  logic                     train_i,
  input  logic                     new_i,
  input  logic                     full_i,
  input  logic                     par_i,
  input  logic [WORD_W*SAMP_W-1:0] cand_i,
  input  logic [WORD_W-1:0]        hit_i,
  input  logic [SH_W-1:0]          first_i,
  input  logic                     any_i,
  output logic [SAMP_W-1:0]        sample_o,
  output logic                     sample_vld_o,
  output logic                     lock_o,
  output logic [SH_W:0]            offset_o
);
  lane_st_e          st_q;
  logic [SH_W-1:0]   ofs_s_q;
  logic              ofs_p_q;
  logic [RUN_W-1:0]  run_q;
  logic [MISS_W-1:0] miss_q;
  logic [SAMP_W-1:0] smp_q;
  logic              svld_q;

  logic              eval;
  logic              on_phase;
  logic              sel_hit;
  logic [SAMP_W-1:0] sel_cand;

  assign eval     = new_i & full_i;
  assign on_phase = (par_i == ofs_p_q);
  assign sel_hit  = hit_i[ofs_s_q];
  assign sel_cand = cand_i[ofs_s_q*SAMP_W +: SAMP_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_SEARCH;
      ofs_s_q <= '0;
      ofs_p_q <= 1'b0;
      run_q   <= '0;
      miss_q  <= '0;
      smp_q   <= '0;
      svld_q  <= 1'b0;
    end else begin
      svld_q <= 1'b0;
      if (realign_i) begin
        st_q    <= ST_SEARCH;
        ofs_s_q <= '0;
        ofs_p_q <= 1'b0;
        run_q   <= '0;
        miss_q  <= '0;
      end else begin
        case (st_q)
          ST_SEARCH: begin
            if (eval && train_i && any_i) begin
              ofs_s_q <= first_i;
              ofs_p_q <= par_i;
              run_q   <= RUN_W'(1);
              st_q    <= ST_QUAL;
            end
          end
          ST_QUAL: begin
            if (!train_i) begin
              st_q  <= ST_SEARCH;
              run_q <= '0;
            end else if (eval && on_phase) begin
              if (sel_hit) begin
                if (run_q == RUN_W'(LOCK_RUN - 1)) begin
                  st_q   <= ST_LOCK;
                  miss_q <= '0;
                end else begin
                  run_q <= run_q + RUN_W'(1);
                end
              end else begin
                st_q  <= ST_SEARCH;
                run_q <= '0;
              end
            end
          end
          ST_LOCK: begin
            if (eval && on_phase) begin
              if (train_i) begin
                if (sel_hit) begin
                  miss_q <= '0;
                end else if (miss_q == MISS_W'(LOSS_RUN - 1)) begin
                  st_q   <= ST_SEARCH;
                  run_q  <= '0;
                  miss_q <= '0;
                end else begin
                  miss_q <= miss_q + MISS_W'(1);
                end
              end else begin
                smp_q  <= sel_cand;
                svld_q <= 1'b1;
                miss_q <= '0;
              end
            end
          end
          default: st_q <= ST_SEARCH;
        endcase
      end
    end
  end

  assign sample_o     = smp_q;
  assign sample_vld_o = svld_q;
  assign lock_o       = (st_q == ST_LOCK);
  assign offset_o     = {ofs_p_q, ofs_s_q};
endmodule

// File: rtl/lane_word_aligner.sv
module lane_word_aligner #(
  parameter int NUM_LANES = 4,
  parameter int WORD_W    = 8,
  parameter logic [2*WORD_W-1:0] TRAIN_PAT = 16'hFF00,
  parameter int LOCK_RUN  = 8,
  parameter int LOSS_RUN  = 4,
  localparam int SAMP_W   = 2 * WORD_W,
  localparam int WIN_W    = 3 * WORD_W,
  localparam int SH_W     = $clog2(WORD_W),
  localparam int OFS_W    = SH_W + 1
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        train_i,
  input  logic                        realign_i,
  input  logic [NUM_LANES-1:0]        word_valid_i,
  input  logic [NUM_LANES*WORD_W-1:0] word_i,
  output logic [NUM_LANES*SAMP_W-1:0] sample_o,
  output logic [NUM_LANES-1:0]        sample_vld_o,
  output logic [NUM_LANES-1:0]        lock_o,
  output logic [NUM_LANES*OFS_W-1:0]  offset_o
);
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
    logic [WIN_W-1:0]         win;
    logic                     full;
    logic                     par;
    logic                     nw;
    logic [WORD_W*SAMP_W-1:0] cand;
    logic [WORD_W-1:0]        hit;
    logic [SH_W-1:0]          first;
    logic                     any;

    lwa_shift_window #(
      .WORD_W   (WORD_W),
      .NUM_WORDS(3)
    ) win_i (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .clr_i (realign_i),
      .vld_i (word_valid_i[l]),
      .word_i(word_i[l*WORD_W +: WORD_W]),
      .win_o (win),
      .full_o(full),
      .par_o (par),
      .new_o (nw)
    );

    lwa_pattern_match #(
      .WORD_W (WORD_W),
      .SAMP_W (SAMP_W),
      .WIN_W  (WIN_W),
      .SH_W   (SH_W),
      .PATTERN(TRAIN_PAT)
    ) match_i (
      .win_i  (win),
      .cand_o (cand),
      .hit_o  (hit),
      .first_o(first),
      .any_o  (any)
    );

    lwa_lane_fsm #(
      .WORD_W  (WORD_W),
      .SAMP_W  (SAMP_W),
      .SH_W    (SH_W),
      .LOCK_RUN(LOCK_RUN),
      .LOSS_RUN(LOSS_RUN)
    ) fsm_i (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .realign_i   (realign_i),
      .train_i     (train_i),
      .new_i       (nw),
      .full_i      (full),
      .par_i       (par),
      .cand_i      (cand),
      .hit_i       (hit),
      .first_i     (first),
      .any_i       (any),
      .sample_o    (sample_o[l*SAMP_W +: SAMP_W]),
      .sample_vld_o(sample_vld_o[l]),
      .lock_o      (lock_o[l]),
      .offset_o    (offset_o[l*OFS_W +: OFS_W])
    );
  end
endmodule

// File: rtl/lwa_checker.sv
module lwa_checker #(
  parameter int NUM_LANES = 4,
  parameter int OFS_W     = 4
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic                       train_i,
  input logic                       realign_i,
  input logic [NUM_LANES-1:0]       word_valid_i,
  input logic [NUM_LANES-1:0]       sample_vld_o,
  input logic [NUM_LANES-1:0]       lock_o,
  input logic [NUM_LANES*OFS_W-1:0] offset_o
);
  for (genvar l = 0; l < NUM_LANES; l++) begin : g_chk
    // R9
    realign_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      realign_i |=> !lock_o[l]);
    // R7
    vld_locked_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sample_vld_o[l] |-> lock_o[l]);
    // R7
    vld_data_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sample_vld_o[l] |-> !$past(train_i));
    // R7
    vld_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sample_vld_o[l] |=> !sample_vld_o[l]);
    // R8
    vld_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sample_vld_o[l] |-> $past(word_valid_i[l], 2));
    // R4
    ofs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_o[l] && $past(lock_o[l])) |-> $stable(offset_o[l*OFS_W +: OFS_W]));
    // R3
    lock_train_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lock_o[l]) |-> $past(train_i));
  end
endmodule

bind lane_word_aligner lwa_checker #(
  .NUM_LANES(NUM_LANES),
  .OFS_W    (OFS_W)
) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .train_i     (train_i),
  .realign_i   (realign_i),
  .word_valid_i(word_valid_i),
  .sample_vld_o(sample_vld_o),
  .lock_o      (lock_o),
  .offset_o    (offset_o)
);

// File: tb/lane_word_aligner_tb_top.sv
module lane_word_aligner_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 4;
  localparam int WW = 8;
  localparam int SW = 16;
  localparam int OW = 4;
  localparam int NROW = 4;
  localparam int DEPTH = 2048;
  localparam logic [15:0] PAT = 16'hFF00;
  // {boundary lane0..lane3, slip lane, inserted bit count}
  localparam logic [20:0] VEC [NROW] = '{
    {4'd0, 4'd5, 4'd10, 4'd15, 2'd0, 3'd2},
    {4'd1, 4'd6, 4'd11, 4'd14, 2'd1, 3'd3},
    {4'd2, 4'd7, 4'd8,  4'd13, 2'd2, 3'd4},
    {4'd3, 4'd4, 4'd9,  4'd12, 2'd3, 3'd2}
  };

  logic             clk;
  logic             rst_ni;
  logic             train_i;
  logic             realign_i;
  logic [NL-1:0]    word_valid_i;
  logic [NL*WW-1:0] word_i;
  logic [NL*SW-1:0] sample_o;
  logic [NL-1:0]    sample_vld_o;
  logic [NL-1:0]    lock_o;
  logic [NL*OW-1:0] offset_o;

  lane_word_aligner dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .train_i     (train_i),
    .realign_i   (realign_i),
    .word_valid_i(word_valid_i),
    .word_i      (word_i),
    .sample_o    (sample_o),
    .sample_vld_o(sample_vld_o),
    .lock_o      (lock_o),
    .offset_o    (offset_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic        bq [NL][0:DEPTH-1];
  int          wr [NL];
  int          rd [NL];
  int          st_prev [NL];
  int          st_last [NL];
  logic [15:0] exp_v [NL][0:63];
  int          eh [NL];
  int          et [NL];
  bit          dropped [NL];
  bit          watch_drop;
  int n_chk, n_fail, m_chk, m_fail, cyc;

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk + m_chk, n_fail + m_fail);
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic push_bits(input int l, input logic [15:0] v, input int n);
    for (int i = n - 1; i >= 0; i--) begin
      bq[l][wr[l]] = v[i];
      wr[l]++;
    end
  endtask

  task automatic push_tr(input int l);
    st_prev[l] = st_last[l];
    st_last[l] = wr[l];
    push_bits(l, PAT, 16);
  endtask

  task automatic push_dat(input int l, input logic [15:0] v);
    exp_v[l][et[l]] = v;
    et[l]++;
    push_bits(l, v, 16);
  endtask

  function automatic bit any_ready();
    for (int l = 0; l < NL; l++) if (wr[l] - rd[l] >= 8) return 1'b1;
    return 1'b0;
  endfunction

  // words go out MSB first; every seventh cycle per lane is a gap with junk (R8)
  task automatic drain();
    while (any_ready()) begin
      @(negedge clk);
      for (int l = 0; l < NL; l++) begin
        if (wr[l] - rd[l] >= 8 && ((cyc + l) % 7) != 5) begin
          for (int b = 0; b < 8; b++) word_i[l*WW + 7 - b] = bq[l][rd[l] + b];
          rd[l] += 8;
          word_valid_i[l] = 1'b1;
        end else begin
          word_i[l*WW +: WW] = 8'h5A;
          word_valid_i[l] = 1'b0;
        end
      end
    end
    @(negedge clk);
    word_valid_i = '0;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_realign();
    @(negedge clk);
    realign_i = 1'b1;
    @(negedge clk);
    realign_i = 1'b0;
    for (int l = 0; l < NL; l++) begin
      wr[l] = 0; rd[l] = 0; eh[l] = 0; et[l] = 0;
      st_prev[l] = -100; st_last[l] = -100;
    end
  endtask

  // training samples not yet evaluated at the switch still come out in data mode
  task automatic enter_data();
    for (int l = 0; l < NL; l++) begin
      if (st_prev[l] >= 0 && 8 * (st_prev[l] / 8) + 24 > rd[l]) begin
        exp_v[l][et[l]] = PAT; et[l]++;
      end
      if (st_last[l] >= 0 && 8 * (st_last[l] / 8) + 24 > rd[l]) begin
        exp_v[l][et[l]] = PAT; et[l]++;
      end
    end
    @(negedge clk);
    train_i = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog (all) act=%0d exp=%0d", cyc, 150000);
      report();
      $finish;
    end
  end

  always @(negedge clk) begin
    if (rst_ni) begin
      for (int l = 0; l < NL; l++) begin
        if (watch_drop && !lock_o[l]) dropped[l] = 1'b1;
        if (sample_vld_o[l]) begin
          m_chk++;
          if (eh[l] < et[l]) begin
            if (sample_o[l*SW +: SW] !== exp_v[l][eh[l]]) begin
              m_fail++;
              $display("FAIL R7 lane%0d sample act=%0h exp=%0h", l, sample_o[l*SW +: SW], exp_v[l][eh[l]]);
            end
            eh[l]++;
          end else begin
            m_fail++;
            $display("FAIL R7/R8 lane%0d unexpected strobe act=%0h exp=none", l, sample_o[l*SW +: SW]);
          end
        end
      end
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; m_chk = 0; m_fail = 0; cyc = 0;
    watch_drop = 1'b0;
    rst_ni = 1'b0; train_i = 1'b1; realign_i = 1'b0;
    word_valid_i = '0; word_i = '0;
    for (int l = 0; l < NL; l++) begin
      wr[l] = 0; rd[l] = 0; eh[l] = 0; et[l] = 0;
      st_prev[l] = -100; st_last[l] = -100; dropped[l] = 1'b0;
    end
    repeat (3) @(negedge clk);
    chk(lock_o == '0, "R1 lock in reset", int'(lock_o), 0);
    chk(sample_vld_o == '0, "R1 strobe in reset", int'(sample_vld_o), 0);
    chk(offset_o == '0, "R1 offset in reset", int'(offset_o), 0);
    rst_ni = 1'b1;

    for (int r = 0; r < NROW; r++) begin
      int sl;
      int amt;
      sl  = int'(VEC[r][4:3]);
      amt = int'(VEC[r][2:0]);
      train_i = 1'b1;
      do_realign();
      if (r > 0) chk(lock_o == '0, "R9 realign clears lock", int'(lock_o), 0);
      for (int l = 0; l < NL; l++) begin
        push_bits(l, PAT, int'(VEC[r][20 - 4*l -: 4]));
        for (int k = 0; k < 14; k++) push_tr(l);
      end
      drain();
      for (int l = 0; l < NL; l++) begin
        chk(lock_o[l] == 1'b1, "R2/R8 lock at boundary", int'(lock_o[l]), 1);
        chk(offset_o[l*OW +: OW] == VEC[r][20 - 4*l -: 4], "R2 offset",
            int'(offset_o[l*OW +: OW]), int'(VEC[r][20 - 4*l -: 4]));
      end
      // slip on one lane
      for (int l = 0; l < NL; l++) dropped[l] = 1'b0;
      watch_drop = 1'b1;
      push_bits(sl, 16'h0000, amt);
      for (int l = 0; l < NL; l++) for (int k = 0; k < 20; k++) push_tr(l);
      drain();
      watch_drop = 1'b0;
      chk(dropped[sl] == 1'b1, "R5 slip drops lock", int'(dropped[sl]), 1);
      for (int l = 0; l < NL; l++) begin
        int eo;
        eo = (l == sl) ? (int'(VEC[r][20 - 4*l -: 4]) + amt) % 16 : int'(VEC[r][20 - 4*l -: 4]);
        chk(lock_o[l] == 1'b1, "R5/R10 lock after slip", int'(lock_o[l]), 1);
        chk(int'(offset_o[l*OW +: OW]) == eo, "R5/R10 offset after slip", int'(offset_o[l*OW +: OW]), eo);
        if (l != sl) chk(dropped[l] == 1'b0, "R10 other lane kept lock", int'(dropped[l]), 0);
      end
      // data mode
      enter_data();
      for (int l = 0; l < NL; l++) begin
        for (int k = 0; k < 6; k++)
          push_dat(l, 16'(16'hA53C + r*16'h1111 + l*16'h0707 + k*16'h1357));
        push_bits(l, 16'h0000, 16);
      end
      drain();
      for (int l = 0; l < NL; l++) begin
        int eo;
        eo = (l == sl) ? (int'(VEC[r][20 - 4*l -: 4]) + amt) % 16 : int'(VEC[r][20 - 4*l -: 4]);
        chk(eh[l] == et[l], "R7 all samples delivered", eh[l], et[l]);
        chk(int'(offset_o[l*OW +: OW]) == eo, "R4 offset held", int'(offset_o[l*OW +: OW]), eo);
      end
      chk(lock_o == '1, "R6 data keeps lock", int'(lock_o), 15);
    end

    // R3: exact word count to lock with boundary 0
    train_i = 1'b1;
    do_realign();
    chk(lock_o == '0, "R9 realign clears lock", int'(lock_o), 0);
    for (int l = 0; l < NL; l++) for (int k = 0; k < 8; k++) push_tr(l);
    drain();
    chk(lock_o == '0, "R3 no lock after 16 words", int'(lock_o), 0);
    for (int l = 0; l < NL; l++) push_bits(l, 16'h00FF, 8);
    drain();
    chk(lock_o == '1, "R3 lock on 17th word", int'(lock_o), 15);
    chk(offset_o == '0, "R3 offset zero", int'(offset_o), 0);

    // R8: junk with valid low in data mode gives no strobe and keeps lock
    enter_data();
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      word_valid_i = '0;
      word_i = {NL{8'(8'hC3 + i)}};
    end
    repeat (4) @(negedge clk);
    chk(lock_o == '1, "R8 lock after idle junk", int'(lock_o), 15);
    chk(eh[0] == et[0], "R8 no strobe from junk", eh[0], et[0]);

    report();
    $finish;
  end
endmodule